// File: doc/BRIEF.md
# Job Ring Queue Manager

This block tracks one pair of descriptor rings for an offload engine. Software places descriptor words into an inbound ring held in an internal RAM, then announces how many it placed by writing a count to an add register. A fixed-latency processing model takes inbound entries one at a time, in the order they were submitted, and copies each descriptor word into the next slot of an outbound ring. Software reads how many outbound slots are full, reads the returned descriptor words to match them against its own records, and releases slots by writing a count to a remove register.

The ring size is a power of two chosen by an exponent register. The exponent, together with two base address registers, may be changed only while the block is disabled. Dropping the enable bit clears all indices and counts. A two-bit status register records completions and rejected requests. Each bit is cleared by writing a one to it, and the interrupt output is high while any bit is set.

Top module: `job_ring_mgr`

## Requirements
- R1: After reset the block is disabled, the size exponent is LOG2_MAX, the inbound free count equals the full ring size, the outbound full count is 0, status is 0 and irq is low.
- R2: While enabled, writing N (N not above the inbound free count) to the add register lowers the inbound free count by N from the next cycle on.
- R3: Each completion moves the oldest pending inbound entry to the outbound ring, carrying the descriptor word stored at that inbound slot. The move takes effect exactly LATENCY clock edges after the entry becomes the head with outbound room, and completions are at least LATENCY cycles apart.
- R4: Writing M (M not above the outbound full count) to the remove register frees M outbound slots.
- R5: An add of N above the free count, a remove of M above the full count, or either with a nonzero value while disabled, is ignored and sets status bit 1 (error). A value of 0 has no effect and sets no error.
- R6: Indices wrap modulo the ring size 2^k. The j-th completed entry since enable is readable at outbound index j mod 2^k, and counts never exceed 2^k.
- R7: While the outbound ring is full, no completion happens. Processing resumes once slots are removed.
- R8: Status bit 0 (done) is set by every completion. Writing the status register clears each bit whose written bit is 1, and irq is high exactly while a status bit is set.
- R9: The base registers and the size exponent accept writes only while disabled. Exponent values outside 1..LOG2_MAX are ignored.
- R10: Clearing the enable bit resets indices and counts: inbound free becomes the ring size and outbound full becomes 0.
- R11: Register offsets: 0 control (bit 0 enable), 1 inbound base, 2 outbound base, 3 size exponent, 4 inbound free (read), 5 add (write), 6 outbound full (read), 7 remove (write), 8 status. Write-only and unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_addr | input | 4 | Register write offset |
| reg_wr_data | input | DW | Register write data |
| reg_rd_addr | input | 4 | Register read offset |
| reg_rd_data | output | DW | Register read data (combinational) |
| ib_wr_en | input | 1 | Inbound descriptor RAM write strobe |
| ib_wr_idx | input | LOG2_MAX | Inbound slot to write |
| ib_wr_data | input | DW | Descriptor word |
| ob_rd_idx | input | LOG2_MAX | Outbound slot to read |
| ob_rd_data | output | DW | Returned descriptor word (combinational) |
| irq | output | 1 | Interrupt, high while any status bit is set |

## Verification
The assertions take for granted that software writes descriptor words only into inbound slots that are not pending. They also assume the exponent is changed only while disabled, so counts are already zero when the size changes. The stimulus keeps to this by letting the engine drain before every add or remove, then computing the free slots from its own model and writing descriptors only into those slots. Over-limit requests are generated on purpose, from a drained state in which the real counts equal the model's, so the assertions on rejected requests see exactly the intended boundary.

// File: rtl/jrq_pkg.sv
package jrq_pkg;
  localparam int REG_AW = 4;
  localparam logic [REG_AW-1:0] A_CTRL     = 4'd0;
  localparam logic [REG_AW-1:0] A_IN_BASE  = 4'd1;
  localparam logic [REG_AW-1:0] A_OUT_BASE = 4'd2;
  localparam logic [REG_AW-1:0] A_SIZE     = 4'd3;
  localparam logic [REG_AW-1:0] A_IN_FREE  = 4'd4;
  localparam logic [REG_AW-1:0] A_ADD      = 4'd5;
  localparam logic [REG_AW-1:0] A_OUT_FULL = 4'd6;
  localparam logic [REG_AW-1:0] A_REMOVE   = 4'd7;
  localparam logic [REG_AW-1:0] A_STATUS   = 4'd8;
  localparam int ST_DONE = 0;
  localparam int ST_ERR  = 1;
  localparam int ST_W    = 2;
endpackage

// File: rtl/jrq_ring_track.sv
module jrq_ring_track #(
  parameter int IDX_W = 4,
  parameter int CNT_W = IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic [IDX_W-1:0] size_mask,
  input  logic [CNT_W-1:0] ring_size,
  input  logic             push_en,
  input  logic [CNT_W-1:0] push_n,
  input  logic             pop_en,
  input  logic [CNT_W-1:0] pop_n,
  output logic [IDX_W-1:0] head_idx,
  output logic [IDX_W-1:0] tail_idx,
  output logic [CNT_W-1:0] count
);
  logic [IDX_W-1:0] head_q, head_nxt;
  logic [IDX_W-1:0] tail_q, tail_nxt;
  logic [CNT_W-1:0] cnt_q, cnt_nxt;
  logic [CNT_W-1:0] add_amt, sub_amt;
  logic             upd;

  assign add_amt = push_en ? push_n : '0;
  assign sub_amt = pop_en  ? pop_n  : '0;
  assign upd     = clear | push_en | pop_en;

  always_comb begin
    head_nxt = head_q;
    tail_nxt = tail_q;
    cnt_nxt  = cnt_q;
    if (clear) begin
      head_nxt = '0;
      tail_nxt = '0;
      cnt_nxt  = '0;
    end else begin
      tail_nxt = (tail_q + add_amt[IDX_W-1:0]) & size_mask;
      head_nxt = (head_q + sub_amt[IDX_W-1:0]) & size_mask;
      cnt_nxt  = cnt_q + add_amt - sub_amt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else if (upd) begin
      head_q <= head_nxt;
      tail_q <= tail_nxt;
      cnt_q  <= cnt_nxt;
    end
  end

  assign head_idx = head_q;
  assign tail_idx = tail_q;
  assign count    = cnt_q;

  // R6
  count_le_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= ring_size);
  // R4
  pop_le_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop_en |-> pop_n <= cnt_q);
  // R5
  push_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push_en |-> ({1'b0, cnt_q} + {1'b0, push_n}) <= {1'b0, ring_size});
endmodule

// File: rtl/jrq_engine.sv
module jrq_engine #(
  parameter int LATENCY = 4,
  parameter int CNT_W   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enable,
  input  logic [CNT_W-1:0] in_count,
  input  logic [CNT_W-1:0] out_count,
  input  logic [CNT_W-1:0] ring_size,
  output logic             fire
);
  localparam int TW = (LATENCY > 1) ? $clog2(LATENCY) : 1;
  localparam logic [TW-1:0] T_LAST = TW'(LATENCY - 1);

  logic [TW-1:0] timer_q, timer_nxt;
  logic          work, upd;

  assign work = enable && (in_count != '0) && (out_count < ring_size);
  assign fire = work && (timer_q == T_LAST);
  assign upd  = work || (timer_q != '0);

  always_comb begin
    if (!work || fire) timer_nxt = '0;
    else               timer_nxt = timer_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   timer_q <= '0;
    else if (upd) timer_q <= timer_nxt;
  end

  generate
    if (LATENCY > 1) begin : g_spacing
      // R3
      fire_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> !fire);
    end
  endgenerate
endmodule

// File: rtl/jrq_regs.sv
module jrq_regs import jrq_pkg::*; #(
  parameter int DW       = 32,
  parameter int LOG2_MAX = 4,
  parameter int IDX_W    = LOG2_MAX,
  parameter int CNT_W    = LOG2_MAX + 1,
  parameter int SZ_W     = $clog2(LOG2_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DW-1:0]     wr_data,
  input  logic [REG_AW-1:0] rd_addr,
  output logic [DW-1:0]     rd_data,
  input  logic [CNT_W-1:0]  in_count,
  input  logic [CNT_W-1:0]  out_count,
  input  logic              done_evt,
  output logic              enable,
  output logic [CNT_W-1:0]  ring_size,
  output logic [IDX_W-1:0]  size_mask,
  output logic              add_en,
  output logic [CNT_W-1:0]  add_n,
  output logic              rm_en,
  output logic [CNT_W-1:0]  rm_n,
  output logic              irq
);
  logic              enable_q, enable_nxt;
  logic [SZ_W-1:0]   size_q, size_nxt;
  logic [DW-1:0]     in_base_q, in_base_nxt;
  logic [DW-1:0]     out_base_q, out_base_nxt;
  logic [ST_W-1:0]   status_q, status_nxt, st_set, st_clr;
  logic [CNT_W-1:0]  in_free;
  logic              add_hit, rm_hit, val_nz, add_fits, rm_fits;
  logic              add_err, rm_err, size_ok, st_upd;

  assign ring_size = CNT_W'(1) << size_q;
  assign size_mask = IDX_W'(ring_size - 1'b1);
  assign in_free   = ring_size - in_count;

  assign add_hit  = wr_en && (wr_addr == A_ADD);
  assign rm_hit   = wr_en && (wr_addr == A_REMOVE);
  assign val_nz   = (wr_data != '0);
  assign add_fits = (wr_data <= DW'(in_free));
  assign rm_fits  = (wr_data <= DW'(out_count));

  assign add_en  = add_hit && val_nz && enable_q && add_fits;
  assign add_err = add_hit && val_nz && !(enable_q && add_fits);
  assign rm_en   = rm_hit && val_nz && enable_q && rm_fits;
  assign rm_err  = rm_hit && val_nz && !(enable_q && rm_fits);
  assign add_n   = wr_data[CNT_W-1:0];
  assign rm_n    = wr_data[CNT_W-1:0];

  assign size_ok = (wr_data >= DW'(1)) && (wr_data <= DW'(LOG2_MAX));

  always_comb begin
    enable_nxt   = enable_q;
    size_nxt     = size_q;
    in_base_nxt  = in_base_q;
    out_base_nxt = out_base_q;
    if (wr_en) begin
      if (wr_addr == A_CTRL) enable_nxt = wr_data[0];
      if (!enable_q) begin
        if (wr_addr == A_IN_BASE)  in_base_nxt  = wr_data;
        if (wr_addr == A_OUT_BASE) out_base_nxt = wr_data;
        if (wr_addr == A_SIZE && size_ok) size_nxt = wr_data[SZ_W-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enable_q   <= 1'b0;
      size_q     <= SZ_W'(LOG2_MAX);
      in_base_q  <= '0;
      out_base_q <= '0;
    end else if (wr_en) begin
      enable_q   <= enable_nxt;
      size_q     <= size_nxt;
      in_base_q  <= in_base_nxt;
      out_base_q <= out_base_nxt;
    end
  end

  always_comb begin
    st_set         = '0;
    st_set[ST_DONE] = done_evt;
    st_set[ST_ERR]  = add_err || rm_err;
    st_clr         = (wr_en && wr_addr == A_STATUS) ? wr_data[ST_W-1:0] : '0;
    status_nxt     = (status_q & ~st_clr) | st_set;
  end

  assign st_upd = done_evt || add_err || rm_err || (wr_en && wr_addr == A_STATUS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      status_q <= '0;
    else if (st_upd) status_q <= status_nxt;
  end

  always_comb begin
    case (rd_addr)
      A_CTRL:     rd_data = DW'(enable_q);
      A_IN_BASE:  rd_data = in_base_q;
      A_OUT_BASE: rd_data = out_base_q;
      A_SIZE:     rd_data = DW'(size_q);
      A_IN_FREE:  rd_data = DW'(in_free);
      A_OUT_FULL: rd_data = DW'(out_count);
      A_STATUS:   rd_data = DW'(status_q);
      default:    rd_data = '0;
    endcase
  end

  assign enable = enable_q;
  assign irq    = |status_q;

  // R9
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (enable_q && $past(enable_q)) |-> ($stable(size_q) && $stable(in_base_q) && $stable(out_base_q)));
  // R5
  err_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_ADD && wr_data != '0 && wr_data > DW'(in_free)) |=> status_q[ST_ERR]);
  // R8
  done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> status_q[ST_DONE]);
  // R8
  done_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == A_STATUS && wr_data[ST_DONE] && !done_evt) |=> !status_q[ST_DONE]);
endmodule

// File: rtl/job_ring_mgr.sv
module job_ring_mgr import jrq_pkg::*; #(
  parameter int DW       = 32,
  parameter int LOG2_MAX = 4,
  parameter int LATENCY  = 4
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr_en,
  input  logic [REG_AW-1:0]   reg_wr_addr,
  input  logic [DW-1:0]       reg_wr_data,
  input  logic [REG_AW-1:0]   reg_rd_addr,
  output logic [DW-1:0]       reg_rd_data,
  input  logic                ib_wr_en,
  input  logic [LOG2_MAX-1:0] ib_wr_idx,
  input  logic [DW-1:0]       ib_wr_data,
  input  logic [LOG2_MAX-1:0] ob_rd_idx,
  output logic [DW-1:0]       ob_rd_data,
  output logic                irq
);
  localparam int IDX_W = LOG2_MAX;
  localparam int CNT_W = LOG2_MAX + 1;
  localparam int DEPTH = 1 << LOG2_MAX;
  localparam int SZ_W  = $clog2(LOG2_MAX + 1);

  logic             enable, fire, add_en, rm_en;
  logic [CNT_W-1:0] ring_size, add_n, rm_n, ib_count, ob_count;
  logic [IDX_W-1:0] size_mask, ib_head, ib_tail, ob_head, ob_tail;
  logic [DW-1:0]    ib_mem [DEPTH];
  logic [DW-1:0]    ob_mem [DEPTH];

  jrq_regs #(.DW(DW), .LOG2_MAX(LOG2_MAX), .IDX_W(IDX_W), .CNT_W(CNT_W), .SZ_W(SZ_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(reg_wr_en), .wr_addr(reg_wr_addr), .wr_data(reg_wr_data),
    .rd_addr(reg_rd_addr), .rd_data(reg_rd_data),
    .in_count(ib_count), .out_count(ob_count), .done_evt(fire),
    .enable(enable), .ring_size(ring_size), .size_mask(size_mask),
    .add_en(add_en), .add_n(add_n), .rm_en(rm_en), .rm_n(rm_n), .irq(irq)
  );

  jrq_ring_track #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_in_ring (
    .clk(clk), .rst_n(rst_n), .clear(!enable),
    .size_mask(size_mask), .ring_size(ring_size),
    .push_en(add_en), .push_n(add_n),
    .pop_en(fire), .pop_n(CNT_W'(1)),
    .head_idx(ib_head), .tail_idx(ib_tail), .count(ib_count)
  );

  jrq_ring_track #(.IDX_W(IDX_W), .CNT_W(CNT_W)) u_out_ring (
    .clk(clk), .rst_n(rst_n), .clear(!enable),
    .size_mask(size_mask), .ring_size(ring_size),
    .push_en(fire), .push_n(CNT_W'(1)),
    .pop_en(rm_en), .pop_n(rm_n),
    .head_idx(ob_head), .tail_idx(ob_tail), .count(ob_count)
  );

  jrq_engine #(.LATENCY(LATENCY), .CNT_W(CNT_W)) u_engine (
    .clk(clk), .rst_n(rst_n), .enable(enable),
    .in_count(ib_count), .out_count(ob_count), .ring_size(ring_size),
    .fire(fire)
  );

  always_ff @(posedge clk) begin
    if (ib_wr_en) ib_mem[ib_wr_idx] <= ib_wr_data;
  end

  always_ff @(posedge clk) begin
    if (fire) ob_mem[ob_tail] <= ib_mem[ib_head];
  end

  assign ob_rd_data = ob_mem[ob_rd_idx];

  // R7
  fire_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> (ob_count < ring_size) && (ib_count != '0));
  // R6
  idx_in_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ib_head | ib_tail | ob_head | ob_tail) & ~size_mask) == '0);
endmodule

// File: tb/test_job_ring_mgr.sv
module test_job_ring_mgr;
  import jrq_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int LOG2_MAX = 4;
  localparam int LAT = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic reg_wr_en;
  logic [REG_AW-1:0] reg_wr_addr, reg_rd_addr;
  logic [DW-1:0] reg_wr_data, reg_rd_data;
  logic ib_wr_en;
  logic [LOG2_MAX-1:0] ib_wr_idx, ob_rd_idx;
  logic [DW-1:0] ib_wr_data, ob_rd_data;
  logic irq;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [DW-1:0] pend[$];
  logic [DW-1:0] outq[$];
  int size, pi, oc;

  always #(CLK_PERIOD/2) clk = ~clk;

  job_ring_mgr #(.DW(DW), .LOG2_MAX(LOG2_MAX), .LATENCY(LAT)) i_job_ring_mgr (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_wr_addr(reg_wr_addr), .reg_wr_data(reg_wr_data),
    .reg_rd_addr(reg_rd_addr), .reg_rd_data(reg_rd_data),
    .ib_wr_en(ib_wr_en), .ib_wr_idx(ib_wr_idx), .ib_wr_data(ib_wr_data),
    .ob_rd_idx(ob_rd_idx), .ob_rd_data(ob_rd_data), .irq(irq)
  );

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [REG_AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_wr_addr = a; reg_wr_data = d;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [REG_AW-1:0] a, output logic [DW-1:0] v);
    reg_rd_addr = a;
    #1;
    v = reg_rd_data;
  endtask

  task automatic put_desc(input int idx, input logic [DW-1:0] v);
    @(negedge clk);
    ib_wr_en = 1'b1; ib_wr_idx = LOG2_MAX'(idx); ib_wr_data = v;
    @(negedge clk);
    ib_wr_en = 1'b0;
  endtask

  function automatic void model_drain();
    while (pend.size() > 0 && outq.size() < size) outq.push_back(pend.pop_front());
  endfunction

  task automatic settle();
    repeat (LAT * (size + 2) + 6) @(negedge clk);
    model_drain();
  endtask

  task automatic check_state(input string tag);
    logic [DW-1:0] v;
    rd(A_IN_FREE, v);  chk({tag, " in_free"}, v, DW'(size - pend.size()));
    rd(A_OUT_FULL, v); chk({tag, " out_full"}, v, DW'(outq.size()));
    for (int j = 0; j < outq.size(); j++) begin
      ob_rd_idx = LOG2_MAX'((oc + j) % size);
      #1;
      chk({tag, " ob entry"}, ob_rd_data, outq[j]);
    end
  endtask

  task automatic check_err(input string tag, input bit exp_err);
    logic [DW-1:0] v;
    rd(A_STATUS, v);
    chk({tag, " err bit"}, DW'(v[ST_ERR]), DW'(exp_err));
    wr(A_STATUS, 32'h3);
  endtask

  task automatic add_jobs(input int n, output bit exp_err);
    int avail;
    avail = size - pend.size();
    exp_err = (n != 0) && (n > avail);
    if (n != 0 && n <= avail) begin
      for (int j = 0; j < n; j++) begin
        logic [DW-1:0] v;
        v = $urandom;
        put_desc((pi + j) % size, v);
        pend.push_back(v);
      end
      pi = (pi + n) % size;
    end
    wr(A_ADD, DW'(n));
  endtask

  task automatic remove(input int m, output bit exp_err);
    exp_err = (m != 0) && (m > outq.size());
    if (m != 0 && !exp_err) begin
      for (int j = 0; j < m; j++) void'(outq.pop_front());
      oc = (oc + m) % size;
    end
    wr(A_REMOVE, DW'(m));
  endtask

  task automatic random_rounds(input int rounds);
    bit e;
    for (int r = 0; r < rounds; r++) begin
      add_jobs($urandom_range(size - pend.size() + 1, 0), e);
      settle();
      check_state("R6 random add");
      check_err("R5 random add", e);
      remove($urandom_range(outq.size() + 1, 0), e);
      settle();
      check_state("R4 random remove");
      check_err("R5 random remove", e);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog R3 run did not complete");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v;
    logic [DW-1:0] d0;
    bit e;
    void'($urandom(32'd20240611));
    rst_n = 1'b0; reg_wr_en = 1'b0; reg_wr_addr = '0; reg_wr_data = '0;
    reg_rd_addr = '0; ib_wr_en = 1'b0; ib_wr_idx = '0; ib_wr_data = '0; ob_rd_idx = '0;
    size = 16; pi = 0; oc = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(A_IN_FREE, v);  chk("R1 in_free", v, 32'd16);
    rd(A_OUT_FULL, v); chk("R1 out_full", v, 32'd0);
    rd(A_STATUS, v);   chk("R1 status", v, 32'd0);
    rd(A_SIZE, v);     chk("R1 size", v, 32'd4);
    rd(A_CTRL, v);     chk("R1 ctrl", v, 32'd0);
    chk("R1 irq", DW'(irq), 32'd0);
    rd(A_ADD, v);      chk("R11 write-only reads 0", v, 32'd0);

    // R9 configuration while disabled
    wr(A_IN_BASE, 32'h1000);
    wr(A_OUT_BASE, 32'h2000);
    wr(A_SIZE, 32'd7);
    rd(A_SIZE, v);     chk("R9 out of range size ignored", v, 32'd4);
    wr(A_SIZE, 32'd2);
    rd(A_SIZE, v);     chk("R9 size accepted", v, 32'd2);
    size = 4;
    wr(A_CTRL, 32'd1);
    wr(A_SIZE, 32'd3);
    rd(A_SIZE, v);     chk("R9 size locked", v, 32'd2);
    wr(A_IN_BASE, 32'h5);
    rd(A_IN_BASE, v);  chk("R9 base locked", v, 32'h1000);
    rd(A_OUT_BASE, v); chk("R9 out base", v, 32'h2000);
    rd(A_IN_FREE, v);  chk("R10 free after enable", v, 32'd4);

    // R2 / R3 latency and returned descriptor
    d0 = 32'hA5A5_0001;
    put_desc(0, d0);
    wr(A_ADD, 32'd1);
    rd(A_IN_FREE, v);  chk("R2 free after add", v, 32'd3);
    repeat (LAT - 1) @(negedge clk);
    rd(A_OUT_FULL, v); chk("R3 not yet complete", v, 32'd0);
    @(negedge clk);
    rd(A_OUT_FULL, v); chk("R3 completed at latency", v, 32'd1);
    ob_rd_idx = '0; #1;
    chk("R3 returned descriptor", ob_rd_data, d0);
    rd(A_STATUS, v);   chk("R8 done bit", v, 32'd1);
    chk("R8 irq high", DW'(irq), 32'd1);
    outq.push_back(d0); pi = 1;

    // R8 write-one-to-clear
    wr(A_STATUS, 32'd1);
    rd(A_STATUS, v);   chk("R8 cleared", v, 32'd0);
    chk("R8 irq low", DW'(irq), 32'd0);

    // R5 overrun and zero writes
    wr(A_ADD, 32'd5);
    rd(A_IN_FREE, v);  chk("R5 overrun add ignored", v, 32'd4);
    rd(A_STATUS, v);   chk("R5 err bit", v, 32'd2);
    wr(A_STATUS, 32'd2);
    wr(A_ADD, 32'd0);
    rd(A_STATUS, v);   chk("R5 zero add no error", v, 32'd0);

    // R7 stall on full outbound, resume after removal
    add_jobs(4, e);
    settle();
    check_state("R7 stalled");
    check_err("R7 stalled", e);
    remove(2, e);
    settle();
    check_state("R7 resumed");
    check_err("R7 resumed", e);
    remove(outq.size() + 1, e);
    settle();
    check_state("R5 overrun remove ignored");
    check_err("R5 overrun remove", e);

    // R10 disable clears counts
    wr(A_CTRL, 32'd0);
    @(negedge clk);
    rd(A_IN_FREE, v);  chk("R10 free reset", v, 32'd4);
    rd(A_OUT_FULL, v); chk("R10 full reset", v, 32'd0);
    pend.delete(); outq.delete(); pi = 0; oc = 0;
    wr(A_ADD, 32'd1);
    rd(A_STATUS, v);   chk("R5 add while disabled", DW'(v[ST_ERR]), 32'd1);
    rd(A_IN_FREE, v);  chk("R5 disabled add ignored", v, 32'd4);
    wr(A_STATUS, 32'h3);

    // R6 wrap with small ring, then full-size ring
    wr(A_CTRL, 32'd1);
    random_rounds(30);
    wr(A_CTRL, 32'd0);
    pend.delete(); outq.delete(); pi = 0; oc = 0;
    wr(A_SIZE, 32'd4);
    size = 16;
    wr(A_CTRL, 32'd1);
    random_rounds(20);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule